// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one 8-bit parallel port channel that moves data between a CPU and a peripheral under a strobe and acknowledge handshake. It raises an interrupt request when the CPU should service the port. A synchronous mode command selects the direction. In input direction the peripheral drives the port pins and pulses an active-low strobe. The word is captured, a buffer-full flag rises, and once the strobe returns high an interrupt is requested if enabled. The CPU read strobe retires both.

In output direction a CPU write loads the output latch and asserts an active-low output-full line toward the peripheral. The peripheral answers with an active-low acknowledge, which turns on the port drivers and releases output-full. Afterwards an interrupt asks the CPU for the next word, and that interrupt clears when the CPU begins its next write. An interrupt-enable flop gates both interrupt sources. It is changed only by a dedicated set/clear command, and it is cleared by reset or by any mode command. All four handshake strobes are asynchronous and are resynchronized into the system clock before use. A status byte exposes the flags.

Top module: `hs_port`

## Requirements
- R1: After reset: ibf=0, obf_n=1, irq=0, pin_oe=0, interrupt enable clear, input direction selected, status byte 0x00.
- R2: In input direction, while the synchronized strobe is low, pin_in is captured into cpu_rdata and ibf is set.
- R3: ibf clears on the rising edge of the synchronized CPU read strobe. If the strobe is low in that same cycle, ibf stays set.
- R4: In input direction, irq rises when strobe is high, ibf is 1 and the enable is 1. It falls on the falling edge of the read strobe, while ibf stays set until the read strobe rises.
- R5: In output direction, the rising edge of the CPU write strobe loads cpu_wdata into pin_out and drives obf_n low. A low acknowledge drives obf_n high.
- R6: In output direction, irq rises when acknowledge is high, obf_n is high and the enable is 1. It falls on the falling edge of the CPU write strobe.
- R7: pin_oe is high only in output direction while acknowledge is low. pin_out keeps the latched word whether or not pin_oe is high.
- R8: ie_wr loads ie_val into the interrupt enable. mode_wr selects the direction from mode_dir and clears the enable, ibf, irq and the output-full state (obf_n=1). Clearing the enable drops irq.
- R9: The status byte is laid out as: bit0 = ibf, bit1 = output full (inverse of obf_n), bit2 = interrupt enable, bit3 = irq, bit4 = direction (1 = output), bits 7:5 = 0.
- R10: A strobe that arrives while ibf is set overwrites the captured word, and ibf stays set.
- R11: Each handshake strobe passes two synchronizer stages. A strobe falling edge changes ibf no earlier than the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode command pulse |
| mode_dir | input | 1 | Direction for mode command (1 = output) |
| ie_wr | input | 1 | Interrupt-enable set/clear command pulse |
| ie_val | input | 1 | Value loaded into the interrupt enable |
| cpu_rd_n | input | 1 | Asynchronous CPU read strobe, active low |
| cpu_wr_n | input | 1 | Asynchronous CPU write strobe, active low |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Captured input word |
| status | output | 8 | Flag byte |
| pin_stb_n | input | 1 | Peripheral strobe, active low |
| pin_ack_n | input | 1 | Peripheral acknowledge, active low |
| pin_in | input | 8 | Port pins, inbound |
| pin_out | output | 8 | Port pins, outbound latch |
| pin_oe | output | 1 | Port driver enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| irq | output | 1 | Interrupt request |

## Verification
The interesting collision is a peripheral strobe held low across the cycle in which the CPU read strobe rises. In that cycle one function sets the buffer-full flag and another clears it. The bench holds the strobe low, pulses the read strobe and then expects ibf still set. A second collision is an enable-clear command landing while an interrupt is pending. The bench expects irq low after it and expects irq to return once the enable is set again with the buffer still full.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  typedef struct packed {
    logic [2:0] rsvd;
    logic       dir_out;
    logic       irq;
    logic       ie;
    logic       obf;
    logic       ibf;
  } hs_stat_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int         N       = 1,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         ie,
  input  logic         stb_s,
  input  logic         rd_s,
  input  logic         rd_rise,
  input  logic         rd_fall,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_q,
  output logic         ibf_q,
  output logic         irq_q
);
  logic ld;
  logic ibf_d, irq_d;

  assign ld = en & ~clr & ~stb_s;

  always_comb begin
    ibf_d = ibf_q;
    irq_d = irq_q;
    if (clr) begin
      ibf_d = 1'b0;
      irq_d = 1'b0;
    end else if (en) begin
      if (!stb_s)       ibf_d = 1'b1;
      else if (rd_rise) ibf_d = 1'b0;
      if (rd_fall || !ie)
        irq_d = 1'b0;
      else if (stb_s && ibf_q && rd_s && !rd_rise)
        irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ibf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ld) data_q <= pin_in;
      ibf_q <= ibf_d;
      irq_q <= irq_d;
    end
  end

  // R2: a low strobe sets the buffer-full flag
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !stb_s) |=> ibf_q);
  // R4: read falling edge retires the input interrupt
  p_irq_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_fall) |=> !irq_q);
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         ie,
  input  logic         ack_s,
  input  logic         wr_s,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic         obf_n_q,
  output logic         irq_q
);
  logic ld;
  logic obf_n_d, irq_d;

  assign ld = en & ~clr & wr_rise;

  always_comb begin
    obf_n_d = obf_n_q;
    irq_d   = irq_q;
    if (clr) begin
      obf_n_d = 1'b1;
      irq_d   = 1'b0;
    end else if (en) begin
      if (wr_rise)     obf_n_d = 1'b0;
      else if (!ack_s) obf_n_d = 1'b1;
      if (wr_fall || !ie)
        irq_d = 1'b0;
      else if (ack_s && obf_n_q && wr_s && !wr_rise)
        irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      obf_n_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (ld) data_q <= wdata;
      obf_n_q <= obf_n_d;
      irq_q   <= irq_d;
    end
  end

  // R5: a low acknowledge without a write releases output-full
  p_obf_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !ack_s && !wr_rise) |=> obf_n_q);
  // R6: write falling edge retires the output interrupt
  p_irq_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_fall) |=> !irq_q);
endmodule

// File: rtl/hs_port.sv
module hs_port
  import hs_port_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic         mode_dir,
  input  logic         ie_wr,
  input  logic         ie_val,
  input  logic         cpu_rd_n,
  input  logic         cpu_wr_n,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  output logic [7:0]   status,
  input  logic         pin_stb_n,
  input  logic         pin_ack_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         pin_oe,
  output logic         ibf,
  output logic         obf_n,
  output logic         irq
);
  localparam int NSIG = 4;

  logic       rst_s_n;
  logic [1:0] rst_q;
  logic [NSIG-1:0] raw, syn;
  logic stb_s, ack_s, rd_s, wr_s;
  logic rd_d, wr_d, rd_rise, rd_fall, wr_rise, wr_fall;
  logic dir_q, dir_d, ie_q, ie_d;
  logic in_irq, out_irq;
  hs_stat_t st;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  assign raw = {pin_stb_n, pin_ack_n, cpu_rd_n, cpu_wr_n};

  hs_sync #(.N(NSIG), .STAGES(SYNC_STAGES), .RST_VAL({NSIG{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d(raw), .q(syn)
  );
  assign {stb_s, ack_s, rd_s, wr_s} = syn;

  assign rd_rise = rd_s & ~rd_d;
  assign rd_fall = ~rd_s & rd_d;
  assign wr_rise = wr_s & ~wr_d;
  assign wr_fall = ~wr_s & wr_d;

  always_comb begin
    dir_d = dir_q;
    ie_d  = ie_q;
    if (mode_wr) begin
      dir_d = mode_dir;
      ie_d  = 1'b0;
    end else if (ie_wr) begin
      ie_d = ie_val;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dir_q <= 1'b0;
      ie_q  <= 1'b0;
      rd_d  <= 1'b1;
      wr_d  <= 1'b1;
    end else begin
      dir_q <= dir_d;
      ie_q  <= ie_d;
      rd_d  <= rd_s;
      wr_d  <= wr_s;
    end
  end

  hs_in_chan #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_s_n), .en(~dir_q), .clr(mode_wr), .ie(ie_q),
    .stb_s(stb_s), .rd_s(rd_s), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .pin_in(pin_in), .data_q(cpu_rdata), .ibf_q(ibf), .irq_q(in_irq)
  );

  hs_out_chan #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_s_n), .en(dir_q), .clr(mode_wr), .ie(ie_q),
    .ack_s(ack_s), .wr_s(wr_s), .wr_rise(wr_rise), .wr_fall(wr_fall),
    .wdata(cpu_wdata), .data_q(pin_out), .obf_n_q(obf_n), .irq_q(out_irq)
  );

  assign irq    = in_irq | out_irq;
  assign pin_oe = dir_q & ~ack_s;

  always_comb begin
    st         = '0;
    st.ibf     = ibf;
    st.obf     = ~obf_n;
    st.ie      = ie_q;
    st.irq     = irq;
    st.dir_out = dir_q;
  end
  assign status = st;

  // R8: a mode command leaves every flag idle
  p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    mode_wr |=> (!ie_q && !irq && !ibf && obf_n));
  // R8: enable command loads the given value
  p_ie_cmd_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ie_wr && !mode_wr) |=> (ie_q == $past(ie_val)));
endmodule

// File: tb/sim_hs_port.sv
`timescale 1ns/1ps
module sim_hs_port;
  localparam int W = 8;
  localparam time TCLK = 20ns;
  // {dir, ie, data}
  localparam logic [9:0] VEC [8] = '{
    10'h0A5, 10'h13C, 10'h2FF, 10'h300,
    10'h15A, 10'h081, 10'h3C3, 10'h27E
  };

  logic clk = 1'b0;
  logic rst_n, mode_wr, mode_dir, ie_wr, ie_val, cpu_rd_n, cpu_wr_n;
  logic [W-1:0] cpu_wdata, cpu_rdata, pin_in, pin_out;
  logic [7:0] status;
  logic pin_stb_n, pin_ack_n, pin_oe, ibf, obf_n, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  hs_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_dir(mode_dir),
    .ie_wr(ie_wr), .ie_val(ie_val), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .status(status),
    .pin_stb_n(pin_stb_n), .pin_ack_n(pin_ack_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ibf(ibf), .obf_n(obf_n), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic d);
    mode_dir = d; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0; cyc(1);
  endtask

  task automatic set_ie(input logic v);
    ie_val = v; ie_wr = 1'b1; cyc(1); ie_wr = 1'b0; cyc(1);
  endtask

  task automatic strobe_in(input logic [W-1:0] d);
    pin_in = d; pin_stb_n = 1'b0; cyc(4); pin_stb_n = 1'b1; cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; mode_wr = 0; mode_dir = 0; ie_wr = 0; ie_val = 0;
    cpu_rd_n = 1; cpu_wr_n = 1; cpu_wdata = '0; pin_in = '0;
    pin_stb_n = 1; pin_ack_n = 1;
    cyc(3); rst_n = 1'b1; cyc(4);

    // R1 reset state, R9 status zero
    chk("R1 ibf", ibf, 0); chk("R1 obf_n", obf_n, 1); chk("R1 irq", irq, 0);
    chk("R1 pin_oe", pin_oe, 0); chk("R9 reset status", status, 8'h00);

    // table-driven transfers
    for (int i = 0; i < 8; i++) begin
      logic d, e;
      logic [7:0] v;
      {d, e, v} = VEC[i];
      set_mode(d);
      set_ie(e);
      if (!d) begin
        strobe_in(v);
        chk("R2 rdata", cpu_rdata, v); chk("R2 ibf", ibf, 1);
        chk("R4 irq after strobe", irq, e);
        chk("R9 status in", status, {3'b0, 1'b0, e, e, 1'b0, 1'b1});
        cpu_rd_n = 0; cyc(4);
        chk("R4 irq after rd fall", irq, 0); chk("R4 ibf during rd", ibf, 1);
        cpu_rd_n = 1; cyc(4);
        chk("R3 ibf after rd", ibf, 0);
      end else begin
        cpu_wdata = v; cpu_wr_n = 0; cyc(4); cpu_wr_n = 1; cyc(4);
        chk("R5 pin_out", pin_out, v); chk("R5 obf_n low", obf_n, 0);
        chk("R7 oe idle", pin_oe, 0); chk("R6 no irq pending", irq, 0);
        chk("R9 status out", status, {3'b0, 1'b1, 1'b0, e, 1'b1, 1'b0});
        pin_ack_n = 0; cyc(4);
        chk("R7 oe on ack", pin_oe, 1); chk("R5 obf released", obf_n, 1);
        chk("R7 data held", pin_out, v);
        pin_ack_n = 1; cyc(4);
        chk("R6 irq after ack", irq, e); chk("R7 oe off", pin_oe, 0);
        cpu_wr_n = 0; cyc(4);
        chk("R6 irq cleared by wr", irq, 0);
        cpu_wr_n = 1; cyc(4);
      end
    end

    // R11 synchronizer latency
    set_mode(0); set_ie(1);
    pin_in = 8'h11; pin_stb_n = 0;
    cyc(1); chk("R11 ibf after 1 edge", ibf, 0);
    cyc(1); chk("R11 ibf after 2 edges", ibf, 0);
    cyc(1); chk("R11 ibf after 3 edges", ibf, 1);
    cyc(2); pin_stb_n = 1; cyc(4);
    chk("R4 irq raised", irq, 1);

    // R10 overwrite while full
    strobe_in(8'h99);
    chk("R10 rdata overwritten", cpu_rdata, 8'h99); chk("R10 ibf held", ibf, 1);

    // R8 enable clear drops irq, re-enable restores it
    set_ie(0); cyc(2);
    chk("R8 irq off with ie=0", irq, 0); chk("R8 ibf kept", ibf, 1);
    set_ie(1); cyc(3);
    chk("R4 irq re-raised", irq, 1);

    // R3 strobe low across read rise keeps ibf
    pin_in = 8'h42; pin_stb_n = 0; cyc(4);
    cpu_rd_n = 0; cyc(4); cpu_rd_n = 1; cyc(4);
    chk("R3 ibf held by strobe", ibf, 1); chk("R2 rdata", cpu_rdata, 8'h42);
    pin_stb_n = 1; cyc(4);

    // R7 ack ignored in input direction
    pin_ack_n = 0; cyc(4);
    chk("R7 no oe in input", pin_oe, 0);
    pin_ack_n = 1; cyc(4);

    // R8 mode command clears everything
    set_mode(0); cyc(1);
    chk("R8 status after mode", status, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule